// File: doc/BRIEF.md
# Ancillary Packet Checksum Checker and Corrector

This block sits in a 10-bit video word stream and checks the checksum of every ancillary data packet it sees. A packet begins after three consecutive valid words of value 000h, 3FFh and 3FFh. The next word is the data identifier. Then come the secondary identifier or block number, the data count and the user words. A checksum word closes the packet. The block forms its own checksum over the packet and compares it with the word that arrives. When the two differ, it raises an error pulse and sets a sticky error bit.

Every word leaves the block one clock after it enters. A word changes on the way through in one case only: the checksum word disagrees and the correction control is high on that word's cycle. The block then replaces the received checksum with the computed one. In every other case the received word passes through unchanged, so a mismatch found with correction off is only reported. The block does not filter or extract packets.

Top module: `anc_csum_fix`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises with `in_valid` low, `out_valid`, `out_word`, `csum_err` and `csum_err_seen` are all zero.
- R2: Every output word equals the input word of the previous cycle, and `out_valid` equals the previous `in_valid`. The only exception is the substitution of R6.
- R3: A packet header is recognised only when three consecutive valid words are 000h, 3FFh and 3FFh. Cycles with `in_valid` low between words are skipped and do not break the sequence. The next valid word is the data identifier.
- R4: The computed checksum is the sum, modulo 512, of bits 8..0 of the identifier, the secondary identifier, the data count and every user word. Bits 8..0 of the checksum word hold that sum, and bit 9 is the inverse of bit 8. Bits 7..0 of the data count word give the number of user words.
- R5: If the received checksum word differs in any bit from the computed one and `fix_en` is low, `csum_err` pulses and the received word is output unchanged.
- R6: If the received checksum word differs and `fix_en` is high, `csum_err` pulses and the output carries the computed checksum in place of the received word.
- R7: A checksum word that matches is output unchanged and raises no error, whatever the value of `fix_en`.
- R8: `csum_err` is high for exactly one cycle. That cycle is the one in which the checksum word appears at the output, with `out_valid` high.
- R9: `csum_err_seen` goes high with `csum_err` and stays high until a cycle with `err_clr` high and no new error. If an error and a clear arrive together, the error wins.
- R10: A data count of zero places the checksum word directly after the data count word.
- R11: `fix_en` is sampled only in the cycle the checksum word is presented at the input. Its value during the other words of the packet has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word qualifier |
| in_word | input | 10 | Input video word |
| fix_en | input | 1 | Replace a checksum that does not match |
| err_clr | input | 1 | Clear the sticky error bit |
| out_valid | output | 1 | Output word qualifier, delayed one cycle |
| out_word | output | 10 | Output video word, delayed one cycle |
| csum_err | output | 1 | One-cycle pulse on a checksum mismatch |
| csum_err_seen | output | 1 | Sticky mismatch indication |

## Verification
The assertions check several properties on every cycle. Words pass through unchanged while correction is off. A matching checksum never produces a pulse or a change to the word. A corrected word always carries bit 9 as the inverse of bit 8. The error pulse always coincides with a valid output. The sticky bit holds until it is cleared. While user words remain, the word count is non-zero. Other behaviours can be shown only by the bench scenarios against its reference model: that the sum is right, including wrap past 511; that headers are found across gaps in `in_valid`; that zero-length packets are handled; and that `fix_en` outside the checksum cycle has no effect.

// File: rtl/anc_csum_pkg.sv
// Shared widths and the packet tracker's state encoding.
// Assumes 10-bit words whose low 9 bits carry the checksummed value.
package anc_csum_pkg;
    localparam int ANC_WORD_W = 10;
    localparam int ANC_CNT_W  = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SDID,
        ST_DC,
        ST_UDW,
        ST_CSUM
    } trk_state_t;
endpackage

// File: rtl/anc_adf_detect.sv
// Header finder: keeps the last three valid words and flags the current
// valid word when those words were 000h, 3FFh, 3FFh in that order.
// Assumes that invalid cycles carry no stream words and are skipped.
module anc_adf_detect #(
    parameter int WORD_W = anc_csum_pkg::ANC_WORD_W,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              adf_hit
);
    localparam logic [WORD_W-1:0] ALL_ZERO = '0;
    localparam logic [WORD_W-1:0] ALL_ONE  = '1;

    logic [WORD_W-1:0] hist [DEPTH];

    // Newest valid word enters stage 0.
    always_ff @(posedge clk) begin
        if (!rst_n)        hist[0] <= ALL_ZERO;
        else if (in_valid) hist[0] <= in_word;
    end

    // Older words shift down the history chain.
    for (genvar g = 1; g < DEPTH; g++) begin : g_hist
        always_ff @(posedge clk) begin
            if (!rst_n)        hist[g] <= ALL_ZERO;
            else if (in_valid) hist[g] <= hist[g-1];
        end
    end

    // Header match: oldest word zero, the two newer ones all ones.
    always_comb begin
        adf_hit = in_valid && (hist[DEPTH-1] == ALL_ZERO)
                  && (hist[1] == ALL_ONE) && (hist[0] == ALL_ONE);
    end
endmodule

// File: rtl/anc_csum_track.sv
// Packet walker: follows identifier, secondary identifier, data count and
// user words, adds the low 9 bits of each word into a running sum, and
// marks the checksum word with the compare result.
// Assumes that user words never imitate the header sequence.
module anc_csum_track #(
    parameter int WORD_W = anc_csum_pkg::ANC_WORD_W,
    parameter int CNT_W  = anc_csum_pkg::ANC_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              adf_hit,
    output logic              at_csum,
    output logic              csum_bad,
    output logic [WORD_W-1:0] csum_calc
);
    import anc_csum_pkg::*;

    localparam int SUM_W = WORD_W - 1;

    trk_state_t       st;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] sum_next;
    logic [CNT_W-1:0] remain;

    // Running sum including the current word.
    always_comb begin
        sum_next = sum + in_word[SUM_W-1:0];
    end

    // Walk the packet fields and accumulate the sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            sum    <= '0;
            remain <= '0;
        end else if (in_valid) begin
            unique case (st)
                ST_IDLE: begin
                    if (adf_hit) begin
                        sum <= in_word[SUM_W-1:0];
                        st  <= ST_SDID;
                    end
                end
                ST_SDID: begin
                    sum <= sum_next;
                    st  <= ST_DC;
                end
                ST_DC: begin
                    sum    <= sum_next;
                    remain <= in_word[CNT_W-1:0];
                    st     <= (in_word[CNT_W-1:0] == '0) ? ST_CSUM : ST_UDW;
                end
                ST_UDW: begin
                    sum    <= sum_next;
                    remain <= remain - 1'b1;
                    if (remain == CNT_W'(1)) st <= ST_CSUM;
                end
                ST_CSUM: begin
                    st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Expected checksum word and the compare against the received one.
    always_comb begin
        csum_calc = {~sum[SUM_W-1], sum};
        at_csum   = in_valid && (st == ST_CSUM);
        csum_bad  = at_csum && (in_word != csum_calc);
    end

    // While user words remain, the count is never zero (R10).
    p_udw_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_UDW) |-> (remain != '0));

    // A header seen in idle always starts a packet (R3).
    p_hdr_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adf_hit && st == ST_IDLE) |=> (st == ST_SDID));
endmodule

// File: rtl/anc_out_stage.sv
// Output register: delays the stream by one cycle and puts in the computed
// checksum when the compare failed and correction is on. Also produces the
// error pulse and the sticky error bit.
// Assumes that at_csum, csum_bad and csum_calc refer to the current input word.
module anc_out_stage #(
    parameter int WORD_W = anc_csum_pkg::ANC_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              at_csum,
    input  logic              csum_bad,
    input  logic [WORD_W-1:0] csum_calc,
    input  logic              fix_en,
    input  logic              err_clr,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              err_pulse,
    output logic              err_sticky
);
    logic do_fix;

    // Substitute only on a failed compare with correction on.
    always_comb begin
        do_fix = csum_bad && fix_en;
    end

    // Register the word, or the replacement, together with its qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            out_word  <= do_fix ? csum_calc : in_word;
        end
    end

    // Error pulse and sticky copy; a new error wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pulse  <= 1'b0;
            err_sticky <= 1'b0;
        end else begin
            err_pulse <= csum_bad;
            if (csum_bad)     err_sticky <= 1'b1;
            else if (err_clr) err_sticky <= 1'b0;
        end
    end

    // With correction off, words come out unchanged (R5).
    p_no_fix_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fix_en |=> (out_word == $past(in_word)));

    // A matching checksum is untouched and silent (R7).
    p_match_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (at_csum && !csum_bad) |=> (out_word == $past(in_word)) && !err_pulse);

    // A replaced checksum has bit 9 as the inverse of bit 8 (R6).
    p_fix_format_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (csum_bad && fix_en) |=> (out_word[WORD_W-1] != out_word[WORD_W-2]) && err_pulse);

    // The pulse lines up with a valid output word (R8).
    p_pulse_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> out_valid);

    // The sticky bit holds without a clear (R9).
    p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sticky && !err_clr) |=> err_sticky);
endmodule

// File: rtl/anc_csum_fix.sv
// Top level: header finder, packet walker and output stage in series.
// One clock of latency from in_word to out_word; no back-pressure.
module anc_csum_fix #(
    parameter int WORD_W = anc_csum_pkg::ANC_WORD_W,
    parameter int CNT_W  = anc_csum_pkg::ANC_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              fix_en,
    input  logic              err_clr,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              csum_err,
    output logic              csum_err_seen
);
    logic              adf_hit;
    logic              at_csum;
    logic              csum_bad;
    logic [WORD_W-1:0] csum_calc;

    anc_adf_detect #(.WORD_W(WORD_W)) u_hdr (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .adf_hit(adf_hit)
    );

    anc_csum_track #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .adf_hit(adf_hit), .at_csum(at_csum), .csum_bad(csum_bad),
        .csum_calc(csum_calc)
    );

    anc_out_stage #(.WORD_W(WORD_W)) u_out (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .at_csum(at_csum), .csum_bad(csum_bad), .csum_calc(csum_calc),
        .fix_en(fix_en), .err_clr(err_clr), .out_valid(out_valid),
        .out_word(out_word), .err_pulse(csum_err), .err_sticky(csum_err_seen)
    );
endmodule

// File: tb/anc_csum_fix_test.sv
`timescale 1ns/1ps
module anc_csum_fix_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [9:0] in_word = '0;
    logic       fix_en = 1'b0;
    logic       err_clr = 1'b0;
    logic       out_valid;
    logic [9:0] out_word;
    logic       csum_err;
    logic       csum_err_seen;

    int    total = 0;
    int    bad = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_hist[$];
    int m_st = 0;
    int m_sum = 0;
    int m_rem = 0;
    bit m_sticky = 0;
    bit e_valid = 0;
    bit e_pulse = 0;
    bit e_sticky = 0;
    int e_word = 0;

    always #2.5 clk = ~clk;

    anc_csum_fix uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .fix_en(fix_en), .err_clr(err_clr), .out_valid(out_valid),
        .out_word(out_word), .csum_err(csum_err), .csum_err_seen(csum_err_seen)
    );

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // checksum word as the requirement defines it (R4)
    function automatic int csum_of(int words[$]);
        int s = 0;
        foreach (words[i]) s = (s + (words[i] % 512)) % 512;
        return s + (((s / 256) % 2 == 1) ? 0 : 512);
    endfunction

    // advance the reference by one input cycle
    task automatic model(bit v, int w, bit f, bit c);
        bit pulse = 0;
        bit hit;
        int calc;
        int nw = w;
        if (v) begin
            hit = (m_hist.size() == 3) && m_hist[0] == 0 && m_hist[1] == 1023 && m_hist[2] == 1023;
            case (m_st)
                0: if (hit) begin m_sum = w % 512; m_st = 1; end
                1: begin m_sum = (m_sum + w % 512) % 512; m_st = 2; end
                2: begin
                    m_sum = (m_sum + w % 512) % 512;
                    m_rem = w % 256;
                    m_st = (m_rem == 0) ? 4 : 3;
                end
                3: begin
                    m_sum = (m_sum + w % 512) % 512;
                    m_rem--;
                    if (m_rem == 0) m_st = 4;
                end
                default: begin
                    calc = m_sum + (((m_sum / 256) == 1) ? 0 : 512);
                    if (w != calc) begin
                        pulse = 1;
                        if (f) nw = calc;
                    end
                    m_st = 0;
                end
            endcase
            m_hist.push_back(w);
            if (m_hist.size() > 3) void'(m_hist.pop_front());
        end
        if (pulse) m_sticky = 1;
        else if (c) m_sticky = 0;
        e_valid = v;
        e_word = nw;
        e_pulse = pulse;
        e_sticky = m_sticky;
    endtask

    // compare the outputs, then present one input cycle
    task automatic step(bit v, int w, bit f, bit c);
        @(negedge clk);
        chk(cur_req, "out_valid", out_valid, e_valid);
        chk(cur_req, "out_word", out_word, e_word);
        chk(cur_req, "csum_err", csum_err, e_pulse);
        chk(cur_req, "csum_err_seen", csum_err_seen, e_sticky);
        in_valid = v;
        in_word = w[9:0];
        fix_en = f;
        err_clr = c;
        model(v, w, f, c);
    endtask

    // send a packet; corrupt xors the checksum word, gap adds idle cycles
    task automatic send_pkt(int did, int sdid, int n, int seed, int corrupt,
                            bit f_cs, bit f_body, bit gap);
        int body[$];
        int cs;
        body.push_back(did);
        body.push_back(sdid);
        body.push_back(n);
        for (int i = 0; i < n; i++) body.push_back((seed + i * 149) % 1024 | 1);
        cs = csum_of(body) ^ corrupt;
        step(1, 0, f_body, 0);
        if (gap) step(0, 1023, f_body, 0);
        step(1, 1023, f_body, 0);
        step(1, 1023, f_body, 0);
        foreach (body[i]) begin
            step(1, body[i], f_body, 0);
            if (gap) step(0, 0, f_body, 0);
        end
        step(1, cs, f_cs, 0);
        step(1, 5, f_body, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "out_valid", out_valid, 0);
        chk("R1", "csum_err_seen", csum_err_seen, 0);
        rst_n = 1'b1;
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);

        // R2: plain stream with gaps
        cur_req = "R2";
        for (int i = 0; i < 20; i++) step(i % 3 != 0, (i * 77) % 1000 + 4, i % 2, 0);

        // R7: good packets, correction off and on
        cur_req = "R7";
        send_pkt(10'h061, 10'h102, 4, 33, 0, 0, 0, 0);
        send_pkt(10'h061, 10'h102, 4, 33, 0, 1, 1, 0);

        // R5: bad checksum, report only
        cur_req = "R5";
        send_pkt(10'h141, 10'h101, 3, 200, 10'h004, 0, 0, 0);

        // R6: bad checksum, replace
        cur_req = "R6";
        send_pkt(10'h141, 10'h101, 3, 200, 10'h200, 1, 0, 0);

        // R10: zero data count
        cur_req = "R10";
        send_pkt(10'h050, 10'h020, 0, 0, 0, 1, 0, 0);
        send_pkt(10'h050, 10'h020, 0, 0, 10'h001, 1, 0, 0);

        // R3: idle cycles inside header and packet
        cur_req = "R3";
        send_pkt(10'h0AA, 10'h055, 5, 71, 10'h010, 1, 0, 1);

        // R4: long packet with large words to wrap the sum
        cur_req = "R4";
        send_pkt(10'h1FF, 10'h1FE, 40, 511, 0, 0, 0, 0);
        send_pkt(10'h1FF, 10'h1FE, 40, 511, 10'h100, 1, 0, 0);

        // R11: correction high only off the checksum cycle
        cur_req = "R11";
        send_pkt(10'h0C3, 10'h011, 2, 9, 10'h008, 0, 1, 0);

        // R9: clear, then error and clear in the same cycle
        cur_req = "R9";
        step(0, 0, 0, 1);
        step(0, 0, 0, 0);
        send_pkt(10'h0C3, 10'h011, 2, 9, 10'h002, 0, 0, 0);
        step(1, 0, 0, 0);
        step(1, 1023, 0, 0);
        step(1, 1023, 0, 0);
        step(1, 10'h033, 0, 1);
        step(1, 10'h000, 0, 1);
        step(1, 10'h000, 0, 1);
        step(1, 10'h3AB, 0, 1);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);

        // R8: pulse lasts one cycle after the checksum word
        cur_req = "R8";
        send_pkt(10'h022, 10'h033, 1, 3, 10'h3FF, 1, 1, 0);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule